// File: doc/BRIEF.md
# I2C Command Word Packer

This block turns a batch of I2C messages into the packed 32-bit command words that a byte-oriented I2C engine executes. Each message reaches the block as a descriptor holding a 7-bit target address, a read flag, a byte length and a last-of-batch flag. Its payload bytes follow on a separate byte channel. Every message produces one address byte and then its payload bytes. Each byte goes into one of three slots of a word, and each slot has a 2-bit attribute that tells the engine whether to raise a start condition, continue, or stop after the byte.

At the end of a batch the block fixes the final attribute and pulses `done` with the number of words used. A batch that does not fit in the local buffer is reported as an error and leaves the buffer empty. The engine reads the words through a read port and can write returned data back through a write port while the packer is idle. A later unpack command walks the same byte positions, skips every address position, and streams the returned payload bytes out on a valid/ready channel.

Controller states: `ST_IDLE` (no batch open; accepts a first descriptor, an engine write or an unpack command), `ST_MSG` (batch open, waiting for the next descriptor), `ST_DATA` (taking payload bytes), `ST_FINISH` (stop fix-up, count latch), `ST_SCRUB` (clears every word after an overflow), `ST_DONE` (one-cycle result) and `ST_UNPACK` (streams returned bytes).

Transitions:
- IDLE→DATA and MSG→DATA on a descriptor with non-zero length.
- IDLE/MSG→MSG on a zero-length descriptor that is not last.
- IDLE/MSG→FINISH on a zero-length last descriptor.
- DATA→MSG on the final byte of a non-last message.
- DATA→FINISH on the final byte of the last message.
- FINISH→DONE, or FINISH→SCRUB after an overflow.
- SCRUB→DONE after the final word is cleared.
- DONE→IDLE.
- IDLE→UNPACK on `unp_start`, and UNPACK→IDLE once every packed position has been walked.

Top module: `i2c_cmd_packer`

## Requirements
- R1: The address byte of a message equals the 7-bit address shifted left by one, with bit 0 set to 1 for a read and 0 for a write.
- R2: Bytes take consecutive positions across the whole batch. Position p goes to word p/3, slot p mod 3. Slot k holds its byte in bits (31-8k):(24-8k) and its attribute in bits (7-2k):(6-2k). Bits 1:0 of every word are zero.
- R3: The attribute encoding is START=2'b11, CONT=2'b10, STOP=2'b01 and NOP=2'b00. Address bytes carry START and payload bytes carry CONT.
- R4: When the batch ends, a final byte tagged CONT is retagged STOP. A final address byte (zero-length last message) keeps START.
- R5: `done` is high for exactly one cycle per batch. It comes with `done_words` = ceil(total/3), where total is the sum of each message's length plus one.
- R6: A batch with total greater than 3*DEPTH raises `done_err` with `done_words`=0, and afterwards every buffer word reads zero. A total of exactly 3*DEPTH succeeds with DEPTH words.
- R7: Within the reported words, slots past the batch's final byte read as zero data with NOP attribute, even when an earlier batch filled them.
- R8: After `unp_start` in idle, `ub_byte` presents, in position order, the byte held at each payload position, and skips address positions. `ub_last` marks the final payload byte. A byte held while `ub_ready` is low stays stable. An overflowed batch unpacks to nothing.
- R9: An engine write changes a buffer word only in idle with no descriptor accepted in the same cycle. It is ignored while a batch is open.
- R10: A descriptor is taken only when `in_ready` is high and a payload byte only when `dat_ready` is high. The two are never high together, and neither is high while unpacking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_addr | input | 7 | Target address |
| in_rd | input | 1 | 1 = read message |
| in_len | input | LEN_W | Payload byte count |
| in_last | input | 1 | Final message of the batch |
| dat_valid | input | 1 | Payload byte valid |
| dat_ready | output | 1 | Payload byte accepted when high with dat_valid |
| dat_byte | input | 8 | Payload byte |
| done | output | 1 | One-cycle batch result strobe |
| done_words | output | WW | Words used by the batch |
| done_err | output | 1 | Batch overflowed the buffer |
| eng_addr | input | AW | Engine word address |
| eng_rdata | output | 32 | Word at eng_addr |
| eng_we | input | 1 | Engine write enable |
| eng_wdata | input | 32 | Engine write data |
| unp_start | input | 1 | Start streaming returned bytes |
| ub_valid | output | 1 | Returned byte valid |
| ub_ready | input | 1 | Returned byte accepted |
| ub_byte | output | 8 | Returned byte |
| ub_last | output | 1 | Final returned byte |

## Verification
The hardest case to reach is an overflow that lands on an address byte after the buffer is already full. It must raise the error and also scrub words that a previous batch left behind. The bench first packs a batch that fills exactly 3*DEPTH positions. It then sends the same payload followed by one zero-length message, so the extra address byte is the one that finds no room. The stop fix-up never sees a CONT there, and the scrub state must still zero the whole buffer. A small batch is then packed over the full one to show that the stale slots are gone.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

    typedef enum logic [1:0] {
        ATTR_NOP   = 2'b00,
        ATTR_STOP  = 2'b01,
        ATTR_CONT  = 2'b10,
        ATTR_START = 2'b11
    } attr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MSG,
        ST_DATA,
        ST_FINISH,
        ST_SCRUB,
        ST_DONE,
        ST_UNPACK
    } state_e;

    function automatic logic [31:0] put_slot(input logic [31:0] w, input logic [1:0] s,
                                             input logic [7:0] b, input attr_e a);
        logic [31:0] r;
        r = w;
        case (s)
            2'd0: begin r[31:24] = b; r[7:6] = a; end
            2'd1: begin r[23:16] = b; r[5:4] = a; end
            2'd2: begin r[15:8]  = b; r[3:2] = a; end
            default: r = w;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] get_byte(input logic [31:0] w, input logic [1:0] s);
        logic [7:0] r;
        case (s)
            2'd0:    r = w[31:24];
            2'd1:    r = w[23:16];
            2'd2:    r = w[15:8];
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] get_attr(input logic [31:0] w, input logic [1:0] s);
        logic [1:0] r;
        case (s)
            2'd0:    r = w[7:6];
            2'd1:    r = w[5:4];
            2'd2:    r = w[3:2];
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pkr_word_buf.sv
module pkr_word_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [31:0]   ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [31:0]   rb_data
);
    logic [31:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && waddr == AW'(g))
                mem[g] <= wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/pkr_pos_track.sv
module pkr_pos_track #(
    parameter int DEPTH = 16,
    parameter int WW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(3 * DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [WW-1:0] widx,
    output logic [1:0]    slot,
    output logic [PW-1:0] pos
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx <= '0;
            slot <= '0;
            pos  <= '0;
        end else if (clr) begin
            widx <= '0;
            slot <= '0;
            pos  <= '0;
        end else if (adv) begin
            pos <= pos + PW'(1);
            if (slot == 2'd2) begin
                slot <= 2'd0;
                widx <= widx + WW'(1);
            end else begin
                slot <= slot + 2'd1;
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_packer.sv
module i2c_cmd_packer #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 6,
    localparam int AW   = $clog2(DEPTH),
    localparam int WW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [6:0]       in_addr,
    input  logic             in_rd,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_last,
    input  logic             dat_valid,
    output logic             dat_ready,
    input  logic [7:0]       dat_byte,
    output logic             done,
    output logic [WW-1:0]    done_words,
    output logic             done_err,
    input  logic [AW-1:0]    eng_addr,
    output logic [31:0]      eng_rdata,
    input  logic             eng_we,
    input  logic [31:0]      eng_wdata,
    input  logic             unp_start,
    output logic             ub_valid,
    input  logic             ub_ready,
    output logic [7:0]       ub_byte,
    output logic             ub_last
);
    import pkr_pkg::*;

    localparam int NPOS = 3 * DEPTH;
    localparam int PW   = $clog2(NPOS + 1);
    localparam int MAPN = 1 << PW;

    state_e state_q, state_d;

    logic [WW-1:0]    widx;
    logic [1:0]       slot;
    logic [PW-1:0]    pos;
    logic             pos_adv, pos_clr;

    logic             buf_we;
    logic [AW-1:0]    buf_waddr;
    logic [31:0]      buf_wdata;
    logic [AW-1:0]    rb_addr;
    logic [31:0]      rb_data;

    logic [LEN_W-1:0] len_left_q;
    logic             last_msg_q;
    logic             ovf_q;
    logic             err_q;
    logic [WW-1:0]    words_q;
    logic [AW-1:0]    lw_q;
    logic [1:0]       ls_q;
    logic [PW-1:0]    end_pos_q;
    logic [PW-1:0]    ldat_pos_q;
    logic [MAPN-1:0]  addrmap_q;
    logic [AW-1:0]    scrub_q;

    logic             room, take_desc, take_byte, pk_fire, fix_stop, eng_ok;
    logic             at_end, cur_addr;
    logic [7:0]       pk_byte;
    attr_e            pk_attr;

    pkr_pos_track #(.DEPTH(DEPTH), .WW(WW), .PW(PW)) u_pos (
        .clk(clk), .rst_n(rst_n), .clr(pos_clr), .adv(pos_adv),
        .widx(widx), .slot(slot), .pos(pos)
    );

    pkr_word_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .ra_addr(eng_addr), .ra_data(eng_rdata), .rb_addr(rb_addr), .rb_data(rb_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and strobes
    always_comb begin
        room      = (widx < WW'(DEPTH));
        at_end    = (pos == end_pos_q);
        cur_addr  = addrmap_q[pos];
        in_ready  = (state_q == ST_IDLE) || (state_q == ST_MSG);
        dat_ready = (state_q == ST_DATA);
        done      = (state_q == ST_DONE);
        ub_valid  = (state_q == ST_UNPACK) && !at_end && !cur_addr;
        ub_byte   = get_byte(rb_data, slot);
        ub_last   = (pos == ldat_pos_q);
        take_desc = in_ready && in_valid;
        take_byte = dat_ready && dat_valid;
        pk_fire   = (take_desc || take_byte) && room;
        pk_byte   = take_byte ? dat_byte : {in_addr, in_rd};
        pk_attr   = take_byte ? ATTR_CONT : ATTR_START;
        fix_stop  = (state_q == ST_FINISH) && !ovf_q && (get_attr(rb_data, ls_q) == ATTR_CONT);
        eng_ok    = (state_q == ST_IDLE) && eng_we && !take_desc;
        rb_addr   = (state_q == ST_FINISH) ? lw_q : widx[AW-1:0];

        buf_we    = 1'b0;
        buf_waddr = widx[AW-1:0];
        buf_wdata = '0;
        if (pk_fire) begin
            buf_we    = 1'b1;
            buf_wdata = put_slot((slot == 2'd0) ? 32'h0 : rb_data, slot, pk_byte, pk_attr);
        end else if (fix_stop) begin
            buf_we    = 1'b1;
            buf_waddr = lw_q;
            buf_wdata = put_slot(rb_data, ls_q, get_byte(rb_data, ls_q), ATTR_STOP);
        end else if (state_q == ST_SCRUB) begin
            buf_we    = 1'b1;
            buf_waddr = scrub_q;
        end else if (eng_ok) begin
            buf_we    = 1'b1;
            buf_waddr = eng_addr;
            buf_wdata = eng_wdata;
        end

        pos_adv = pk_fire ||
                  ((state_q == ST_UNPACK) && !at_end && (cur_addr || ub_ready));
        pos_clr = (state_q == ST_DONE) || ((state_q == ST_UNPACK) && at_end);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_MSG: begin
                if (take_desc)
                    state_d = (in_len != '0) ? ST_DATA : (in_last ? ST_FINISH : ST_MSG);
                else if (state_q == ST_IDLE && unp_start)
                    state_d = ST_UNPACK;
            end
            ST_DATA:
                if (take_byte && len_left_q == LEN_W'(1))
                    state_d = last_msg_q ? ST_FINISH : ST_MSG;
            ST_FINISH: state_d = ovf_q ? ST_SCRUB : ST_DONE;
            ST_SCRUB:  if (scrub_q == AW'(DEPTH - 1)) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_UNPACK: if (at_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // batch bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_left_q <= '0;
            last_msg_q <= 1'b0;
            ovf_q      <= 1'b0;
            err_q      <= 1'b0;
            words_q    <= '0;
            lw_q       <= '0;
            ls_q       <= '0;
            end_pos_q  <= '0;
            ldat_pos_q <= '0;
            addrmap_q  <= '0;
            scrub_q    <= '0;
        end else begin
            if (take_desc) begin
                len_left_q <= in_len;
                last_msg_q <= in_last;
                if (state_q == ST_IDLE) begin
                    ovf_q     <= 1'b0;
                    addrmap_q <= MAPN'(1);
                end else if (room) begin
                    addrmap_q[pos] <= 1'b1;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
            if (take_byte) begin
                len_left_q <= len_left_q - LEN_W'(1);
                if (room) ldat_pos_q <= pos;
                else      ovf_q      <= 1'b1;
            end
            if (pk_fire) begin
                lw_q <= widx[AW-1:0];
                ls_q <= slot;
            end
            if (state_q == ST_FINISH) begin
                err_q     <= ovf_q;
                words_q   <= ovf_q ? '0 : ((slot == 2'd0) ? widx : widx + WW'(1));
                end_pos_q <= ovf_q ? '0 : pos;
                scrub_q   <= '0;
            end
            if (state_q == ST_SCRUB)
                scrub_q <= scrub_q + AW'(1);
        end
    end

    assign done_words = words_q;
    assign done_err   = err_q;
endmodule

// File: rtl/pkr_checker.sv
module pkr_checker #(
    parameter int DEPTH = 16,
    parameter int WW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          dat_ready,
    input logic          done,
    input logic [WW-1:0] done_words,
    input logic          done_err,
    input logic          ub_valid,
    input logic          ub_ready,
    input logic [7:0]    ub_byte,
    input logic          ub_last
);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_err_zero_words: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> (done_words == '0));

    a_r5_words_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_err) |-> (done_words != '0 && done_words <= WW'(DEPTH)));

    a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && dat_ready));

    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ub_valid && !ub_ready) |=> (ub_valid && $stable(ub_byte) && $stable(ub_last)));

    a_r10_unpack_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ub_valid |-> (!in_ready && !dat_ready));
endmodule

bind i2c_cmd_packer pkr_checker #(.DEPTH(DEPTH), .WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .dat_ready(dat_ready),
    .done(done), .done_words(done_words), .done_err(done_err),
    .ub_valid(ub_valid), .ub_ready(ub_ready), .ub_byte(ub_byte), .ub_last(ub_last)
);

// File: tb/i2c_cmd_packer_bench.sv
`timescale 1ns/1ps
module i2c_cmd_packer_bench;
    localparam int DEPTH = 16;
    localparam int LEN_W = 6;
    localparam int AW    = 4;
    localparam int WW    = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_rd = 0, in_last = 0, dat_valid = 0;
    logic [6:0] in_addr = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic [7:0] dat_byte = '0;
    logic in_ready, dat_ready, done, done_err, ub_valid, ub_last;
    logic [WW-1:0] done_words;
    logic [AW-1:0] eng_addr = '0;
    logic [31:0] eng_rdata, eng_wdata = '0;
    logic eng_we = 0, unp_start = 0, ub_ready = 0;
    logic [7:0] ub_byte;

    always #2.5 clk = ~clk;

    i2c_cmd_packer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_i2c_cmd_packer (.*);

    int checks = 0, errors = 0;
    logic [6:0] m_addr [8];
    logic       m_rd   [8];
    int         m_len  [8];
    logic [7:0] eb [64];
    logic [1:0] ea [64];
    int en;
    logic got_done, got_err;
    logic [WW-1:0] got_words;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int i, input int j, input int seed);
        return 8'((seed * 37 + i * 59 + j * 11 + 5) & 255);
    endfunction

    // independent model of the packed image
    task automatic model(input int nmsg, input int seed);
        en = 0;
        for (int i = 0; i < nmsg; i++) begin
            if (en < 64) begin eb[en] = {m_addr[i], m_rd[i]}; ea[en] = 2'b11; end
            en++;
            for (int j = 0; j < m_len[i]; j++) begin
                if (en < 64) begin eb[en] = dbyte(i, j, seed); ea[en] = 2'b10; end
                en++;
            end
        end
        if (en <= 64 && ea[en-1] == 2'b10) ea[en-1] = 2'b01;
    endtask

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 3; k++) begin
            if (3 * w + k < en) begin
                r[31-8*k -: 8] = eb[3*w+k];
                r[7-2*k -: 2]  = ea[3*w+k];
            end
        end
        return r;
    endfunction

    task automatic rd_word(input int a, output logic [31:0] d);
        @(negedge clk);
        eng_addr = AW'(a);
        #1 d = eng_rdata;
    endtask

    task automatic drive_batch(input int nmsg, input int seed, input bit inject);
        for (int i = 0; i < nmsg; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1; in_addr = m_addr[i]; in_rd = m_rd[i];
            in_len = LEN_W'(m_len[i]); in_last = (i == nmsg - 1);
            @(negedge clk);
            in_valid = 0;
            for (int j = 0; j < m_len[i]; j++) begin
                if (inject && i == 0 && j == 0) begin
                    eng_we = 1; eng_addr = '0; eng_wdata = 32'hDEADBEEF;
                    @(negedge clk);
                    eng_we = 0;
                end
                while (!dat_ready) @(negedge clk);
                dat_valid = 1; dat_byte = dbyte(i, j, seed);
                @(negedge clk);
                dat_valid = 0;
            end
        end
        got_done = 0;
        for (int n = 0; n < 200 && !got_done; n++) begin
            if (done) begin got_done = 1; got_words = done_words; got_err = done_err; end
            else @(negedge clk);
        end
    endtask

    task automatic run_and_check(input int nmsg, input int seed, input bit inject, input string req);
        logic [31:0] d;
        bit xerr;
        int xw;
        model(nmsg, seed);
        drive_batch(nmsg, seed, inject);
        xerr = (en > 3 * DEPTH);
        xw   = xerr ? 0 : (en + 2) / 3;
        chk(got_done, "R5", {req, " done pulse"}, 32'(got_done), 32'd1);
        chk(got_words == WW'(xw), "R5", {req, " word count"}, 32'(got_words), 32'(xw));
        chk(got_err == xerr, "R6", {req, " error flag"}, 32'(got_err), 32'(xerr));
        for (int w = 0; w < DEPTH; w++) begin
            rd_word(w, d);
            if (xerr)
                chk(d == 32'h0, "R6", {req, " scrubbed word"}, d, 32'h0);
            else if (w < xw)
                chk(d == exp_word(w), req, $sformatf("word %0d", w), d, exp_word(w));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(in_ready && !dat_ready && !done && !ub_valid, "R10", "reset handshake state",
            {in_ready, dat_ready, done, ub_valid}, 32'h8);
        rd_word(5, d);
        chk(d == 0, "R2", "reset buffer word", d, 0);
    endtask

    task automatic t_single_write();
        m_addr[0] = 7'h50; m_rd[0] = 0; m_len[0] = 2;
        run_and_check(1, 3, 0, "R1 R3 R4 single write");
    endtask

    task automatic t_quick_read();
        logic [31:0] d;
        m_addr[0] = 7'h3C; m_rd[0] = 1; m_len[0] = 0;
        run_and_check(1, 4, 0, "R4 quick read");
        rd_word(0, d);
        chk(d == 32'h790000C0, "R1", "read address keeps START", d, 32'h790000C0);
    endtask

    task automatic t_combined();
        m_addr[0] = 7'h21; m_rd[0] = 0; m_len[0] = 1;
        m_addr[1] = 7'h21; m_rd[1] = 1; m_len[1] = 3;
        run_and_check(2, 9, 0, "R2 R3 combined");
    endtask

    task automatic t_full_then_shrink();
        for (int i = 0; i < 3; i++) begin m_addr[i] = 7'(16 + i); m_rd[i] = i[0]; m_len[i] = 15; end
        run_and_check(3, 21, 0, "R6 exact fill");
        m_addr[0] = 7'h11; m_rd[0] = 0; m_len[0] = 3;
        run_and_check(1, 22, 0, "R7 stale slots cleared");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 3; i++) begin m_addr[i] = 7'(40 + i); m_rd[i] = 0; m_len[i] = 15; end
        run_and_check(3, 30, 0, "R6 refill");
        m_addr[3] = 7'h0A; m_rd[3] = 1; m_len[3] = 0;
        run_and_check(4, 30, 0, "R6 overflow on address");
        unp_start = 1; @(negedge clk); unp_start = 0;
        begin
            bit seen = 0;
            for (int n = 0; n < 10; n++) begin if (ub_valid) seen = 1; @(negedge clk); end
            chk(!seen, "R8", "overflowed batch unpacks nothing", 32'(seen), 0);
        end
        chk(in_ready, "R8", "idle after empty unpack", 32'(in_ready), 1);
    endtask

    task automatic t_engine_ignored();
        m_addr[0] = 7'h2B; m_rd[0] = 0; m_len[0] = 4;
        run_and_check(1, 50, 1, "R9 engine write during batch");
    endtask

    task automatic t_unpack();
        logic [31:0] d;
        logic [7:0] xb [4] = '{8'h22, 8'h44, 8'h55, 8'h66};
        int k = 0;
        int lastk = -1;
        m_addr[0] = 7'h21; m_rd[0] = 0; m_len[0] = 1;
        m_addr[1] = 7'h21; m_rd[1] = 1; m_len[1] = 3;
        run_and_check(2, 60, 0, "R8 setup");
        @(negedge clk); eng_we = 1; eng_addr = 0; eng_wdata = 32'h11223344;
        @(negedge clk); eng_addr = 1; eng_wdata = 32'h44556677;
        @(negedge clk); eng_we = 0;
        rd_word(1, d);
        chk(d == 32'h44556677, "R9", "idle engine write lands", d, 32'h44556677);
        @(negedge clk); unp_start = 1;
        @(negedge clk); unp_start = 0;
        for (int c = 0; c < 60 && k < 4; c++) begin
            ub_ready = c[0];
            #0.1;
            if (ub_valid && ub_ready) begin
                chk(ub_byte == xb[k], "R8", $sformatf("returned byte %0d", k), 32'(ub_byte), 32'(xb[k]));
                if (ub_last) lastk = k;
                k++;
            end
            @(negedge clk);
        end
        ub_ready = 0;
        chk(k == 4, "R8", "returned byte count", 32'(k), 4);
        chk(lastk == 3, "R8", "last flag position", 32'(lastk), 3);
        repeat (3) @(negedge clk);
        chk(in_ready && !ub_valid, "R10", "idle after unpack", 32'(in_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single_write();
        t_quick_read();
        t_combined();
        t_full_then_shrink();
        t_overflow();
        t_engine_ignored();
        t_unpack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule